// File: doc/BRIEF.md
# L2 Cache Eviction Sequencer

This block runs the eviction of a dirty line from an external direct-mapped second-level cache. A processor bus transaction that misses on a dirty line raises a request carrying the line index and a flag that says whether the transaction is a burst read. The sequencer reads the victim's tag from the tag RAM, rebuilds the full victim address from the returned tag bits and the index, rewrites the line's status, and then reads the line out of the data RAM beat by beat so that the memory write path can store it.

For a burst read the processor is not sent back to retry. Its address phase is acknowledged at once, and the new memory read proceeds in parallel. Only the column strobes of that read are held off until the eviction is complete, so the row access overlaps the eviction. For every other transaction the bus retry line is pulsed. The tag status rewrite runs either as a separate write cycle after the tag read (normal timing) or inside the last cycle of the tag read (fast timing). The mode is chosen by a configuration input.

Top module: `l2_evict_seq`

## Requirements
- R1: A request is accepted only on a clock edge where the sequencer is idle and `req_ready` is high. While an eviction runs, `req_ready` is low, and `req_valid`, `req_index`, `req_burst_rd` and `cfg_fast` have no effect on `tag_idx` or `victim_addr` or on the timing of that eviction.
- R2: For a request with `req_burst_rd`=0, `bus_retry` is high for exactly the one cycle after acceptance, and `bus_ack` stays low.
- R3: For a request with `req_burst_rd`=1, `bus_ack` is high for exactly the one cycle after acceptance, and `bus_retry` stays low.
- R4: For a burst-read request, `col_hold` is high from the cycle after acceptance through the last data beat, and low in the `done` cycle. For other requests it stays low.
- R5: `tag_oe` is high for TAG_RD_LAT consecutive cycles, starting the cycle after acceptance. Throughout that time, `tag_idx` shows the accepted index.
- R6: `victim_addr` becomes {`tag_addr_i` sampled in the last `tag_oe` cycle, accepted index} (tag bits in the upper TAG_W bits), and it holds that value until the next eviction captures. The tag word's status lines are not connected to the block.
- R7: In normal timing (`cfg_fast`=0 at acceptance), the cycle after the tag read has `tag_we`=1 and `tag_oe`=0, with `tag_addr_o` equal to the captured tag bits and `tag_valid_o`=1, `tag_dirty_o`=0. Outside that cycle, `tag_addr_o` is zero.
- R8: In fast timing (`cfg_fast`=1 at acceptance), `tag_valid_o`=1 and `tag_dirty_o`=0 are driven in every `tag_oe` cycle. `tag_we` is high only in the last `tag_oe` cycle, and no separate update cycle follows.
- R9: `tag_valid_oe` is high only while a status value is driven (R7, R8), and only when `cfg_l2_present`=1 and `cfg_multi_proc`=0. Otherwise, the valid pin is left floating.
- R10: `data_rd` is high for BEATS consecutive cycles, starting right after the tag phase: the cycle after the update cycle in normal timing, or the cycle after the last `tag_oe` in fast timing. `data_beat` counts 0 to BEATS-1 during those cycles and is 0 at other times.
- R11: `done` is a one-cycle pulse in the cycle after the last beat, and `req_ready` is high again in the following cycle.
- R12: The timing mode is latched at acceptance. A change of `cfg_fast` during an eviction does not alter that eviction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fast | input | 1 | 1 selects fast tag-update timing |
| cfg_l2_present | input | 1 | An L2 cache is fitted |
| cfg_multi_proc | input | 1 | System is configured as multiprocessor |
| req_valid | input | 1 | Eviction request |
| req_burst_rd | input | 1 | Triggering transaction is a burst read |
| req_index | input | IDX_W | Cache line index of the victim |
| req_ready | output | 1 | Sequencer idle, request may be accepted |
| bus_retry | output | 1 | Retry pulse to the processor bus |
| bus_ack | output | 1 | Address acknowledge pulse to the processor bus |
| col_hold | output | 1 | Holds off the memory controller's column strobes |
| tag_idx | output | IDX_W | Low-order index address to the tag RAM |
| tag_oe | output | 1 | Tag RAM output enable |
| tag_we | output | 1 | Tag RAM write enable |
| tag_addr_i | input | TAG_W | Address bits returned by the tag RAM |
| tag_addr_o | output | TAG_W | Address bits written during a normal update |
| tag_valid_o | output | 1 | Valid status value written to the tag |
| tag_valid_oe | output | 1 | Pad enable for the valid pin |
| tag_dirty_o | output | 1 | Dirty status value written to the tag |
| data_rd | output | 1 | Data RAM read strobe |
| data_beat | output | $clog2(BEATS) | Beat number of the data read |
| done | output | 1 | Eviction complete pulse |
| victim_addr | output | TAG_W+IDX_W | Full address of the evicted line |

## Verification
Every output is registered, so with an acceptance edge counted as cycle 0, the bus pulse and the first `tag_oe` appear in cycle 1. The write enable appears in cycle TAG_RD_LAT (fast) or TAG_RD_LAT+1 (normal). Data beats run from cycle S to S+BEATS-1, where S is TAG_RD_LAT+1 (fast) or TAG_RD_LAT+2 (normal), `done` comes at S+BEATS, and `req_ready` returns at S+BEATS+1. The bench accepts a request at a known edge and compares every output on the falling edge of each of those cycles against values derived from this count. It sweeps every index, both modes, both request kinds and three pad configurations, and it changes the request inputs and the mode just after acceptance.

// File: rtl/l2e_pkg.sv
package l2e_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_TRD  = 3'd1,
    ST_TUPD = 3'd2,
    ST_DRD  = 3'd3,
    ST_DONE = 3'd4
  } evict_st_t;
endpackage

// File: rtl/l2e_ctrl.sv
module l2e_ctrl
  import l2e_pkg::*;
#(
  parameter int IDX_W      = 4,
  parameter int TAG_RD_LAT = 3,
  parameter int BEATS      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_fast,
  input  logic             req_valid,
  input  logic             req_burst_rd,
  input  logic [IDX_W-1:0] req_index,
  output logic             req_ready,
  output logic             bus_retry,
  output logic             bus_ack,
  output logic             col_hold,
  output logic [IDX_W-1:0] tag_idx,
  output logic             tag_oe,
  output logic             tag_we,
  output logic             upd_drv,
  output logic             addr_drv,
  output logic             cap,
  output logic             data_rd,
  output logic [$clog2(BEATS)-1:0] data_beat,
  output logic             done
);
  localparam int MAXC = (TAG_RD_LAT > BEATS) ? TAG_RD_LAT : BEATS;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int BW   = $clog2(BEATS);
  localparam logic [CW-1:0] TRD_LAST = CW'(TAG_RD_LAT - 1);
  localparam logic [CW-1:0] DRD_LAST = CW'(BEATS - 1);

  evict_st_t st, st_n;
  logic [CW-1:0] cnt, cnt_n;
  logic fast_q, fast_n, burst_q, burst_n, accept;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    fast_n  = fast_q;
    burst_n = burst_q;
    accept  = (st == ST_IDLE) && req_valid;
    case (st)
      ST_IDLE: if (req_valid) begin
        st_n    = ST_TRD;
        cnt_n   = '0;
        fast_n  = cfg_fast;
        burst_n = req_burst_rd;
      end
      ST_TRD: if (cnt == TRD_LAST) begin
        cnt_n = '0;
        st_n  = fast_q ? ST_DRD : ST_TUPD;
      end else begin
        cnt_n = cnt + 1'b1;
      end
      ST_TUPD: begin
        st_n  = ST_DRD;
        cnt_n = '0;
      end
      ST_DRD: if (cnt == DRD_LAST) begin
        st_n  = ST_DONE;
        cnt_n = '0;
      end else begin
        cnt_n = cnt + 1'b1;
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  assign cap = (st == ST_TRD) && (cnt == TRD_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      fast_q    <= 1'b0;
      burst_q   <= 1'b0;
      tag_idx   <= '0;
      req_ready <= 1'b1;
      bus_retry <= 1'b0;
      bus_ack   <= 1'b0;
      col_hold  <= 1'b0;
      tag_oe    <= 1'b0;
      tag_we    <= 1'b0;
      upd_drv   <= 1'b0;
      addr_drv  <= 1'b0;
      data_rd   <= 1'b0;
      data_beat <= '0;
      done      <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      fast_q    <= fast_n;
      burst_q   <= burst_n;
      if (accept) tag_idx <= req_index;
      req_ready <= (st_n == ST_IDLE);
      bus_retry <= accept && !req_burst_rd;
      bus_ack   <= accept && req_burst_rd;
      col_hold  <= burst_n && (st_n == ST_TRD || st_n == ST_TUPD || st_n == ST_DRD);
      tag_oe    <= (st_n == ST_TRD);
      tag_we    <= (st_n == ST_TUPD) || (st_n == ST_TRD && fast_n && cnt_n == TRD_LAST);
      upd_drv   <= (st_n == ST_TUPD) || (st_n == ST_TRD && fast_n);
      addr_drv  <= (st_n == ST_TUPD);
      data_rd   <= (st_n == ST_DRD);
      data_beat <= (st_n == ST_DRD) ? cnt_n[BW-1:0] : '0;
      done      <= (st_n == ST_DONE);
    end
  end

  AST_RETRY_ACK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(bus_retry && bus_ack)); // R2

  AST_OE_WE_FAST: assert property (@(posedge clk) disable iff (rst)
    (tag_oe && tag_we) |-> fast_q); // R8

  AST_WE_AFTER_OE: assert property (@(posedge clk) disable iff (rst)
    (tag_we && !tag_oe) |-> $past(tag_oe)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && req_ready)); // R11

  AST_HOLD_END: assert property (@(posedge clk) disable iff (rst)
    $fell(col_hold) |-> done); // R4

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_oe) |-> $past(req_ready)); // R1
endmodule

// File: rtl/l2e_tag_port.sv
module l2e_tag_port #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cap,
  input  logic                   upd_drv,
  input  logic                   addr_drv,
  input  logic                   cfg_l2_present,
  input  logic                   cfg_multi_proc,
  input  logic [IDX_W-1:0]       tag_idx,
  input  logic [TAG_W-1:0]       tag_addr_i,
  output logic [TAG_W-1:0]       tag_addr_o,
  output logic                   tag_valid_o,
  output logic                   tag_valid_oe,
  output logic                   tag_dirty_o,
  output logic [TAG_W+IDX_W-1:0] victim_addr
);
  always_ff @(posedge clk) begin
    if (rst) victim_addr <= '0;
    else if (cap) victim_addr <= {tag_addr_i, tag_idx};
  end

  assign tag_addr_o   = addr_drv ? victim_addr[TAG_W+IDX_W-1:IDX_W] : '0;
  assign tag_valid_o  = upd_drv;
  assign tag_dirty_o  = 1'b0;
  assign tag_valid_oe = upd_drv && cfg_l2_present && !cfg_multi_proc;

  AST_VOE_CFG: assert property (@(posedge clk) disable iff (rst)
    tag_valid_oe |-> (cfg_l2_present && !cfg_multi_proc && tag_valid_o)); // R9

  AST_VICTIM_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$past(cap) |-> $stable(victim_addr)); // R6
endmodule

// File: rtl/l2_evict_seq.sv
module l2_evict_seq #(
  parameter int IDX_W      = 4,
  parameter int TAG_W      = 6,
  parameter int TAG_RD_LAT = 3,
  parameter int BEATS      = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_fast,
  input  logic                     cfg_l2_present,
  input  logic                     cfg_multi_proc,
  input  logic                     req_valid,
  input  logic                     req_burst_rd,
  input  logic [IDX_W-1:0]         req_index,
  output logic                     req_ready,
  output logic                     bus_retry,
  output logic                     bus_ack,
  output logic                     col_hold,
  output logic [IDX_W-1:0]         tag_idx,
  output logic                     tag_oe,
  output logic                     tag_we,
  input  logic [TAG_W-1:0]         tag_addr_i,
  output logic [TAG_W-1:0]         tag_addr_o,
  output logic                     tag_valid_o,
  output logic                     tag_valid_oe,
  output logic                     tag_dirty_o,
  output logic                     data_rd,
  output logic [$clog2(BEATS)-1:0] data_beat,
  output logic                     done,
  output logic [TAG_W+IDX_W-1:0]   victim_addr
);
  logic upd_drv, addr_drv, cap;

  l2e_ctrl #(.IDX_W(IDX_W), .TAG_RD_LAT(TAG_RD_LAT), .BEATS(BEATS)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_fast(cfg_fast),
    .req_valid(req_valid), .req_burst_rd(req_burst_rd), .req_index(req_index),
    .req_ready(req_ready), .bus_retry(bus_retry), .bus_ack(bus_ack),
    .col_hold(col_hold), .tag_idx(tag_idx), .tag_oe(tag_oe), .tag_we(tag_we),
    .upd_drv(upd_drv), .addr_drv(addr_drv), .cap(cap),
    .data_rd(data_rd), .data_beat(data_beat), .done(done)
  );

  l2e_tag_port #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tag (
    .clk(clk), .rst(rst), .cap(cap), .upd_drv(upd_drv), .addr_drv(addr_drv),
    .cfg_l2_present(cfg_l2_present), .cfg_multi_proc(cfg_multi_proc),
    .tag_idx(tag_idx), .tag_addr_i(tag_addr_i), .tag_addr_o(tag_addr_o),
    .tag_valid_o(tag_valid_o), .tag_valid_oe(tag_valid_oe),
    .tag_dirty_o(tag_dirty_o), .victim_addr(victim_addr)
  );
endmodule

// File: tb/sim_l2_evict_seq.sv
`timescale 1ns/1ps
module sim_l2_evict_seq;
  localparam int IDX_W = 4;
  localparam int TAG_W = 6;
  localparam int LAT   = 3;
  localparam int BEATS = 4;
  localparam int BW    = $clog2(BEATS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_fast = 1'b0, cfg_l2_present = 1'b1, cfg_multi_proc = 1'b0;
  logic req_valid = 1'b0, req_burst_rd = 1'b0;
  logic [IDX_W-1:0] req_index = '0;
  logic req_ready, bus_retry, bus_ack, col_hold, tag_oe, tag_we;
  logic [IDX_W-1:0] tag_idx;
  logic [TAG_W-1:0] tag_addr_i, tag_addr_o;
  logic tag_valid_o, tag_valid_oe, tag_dirty_o, data_rd, done;
  logic [BW-1:0] data_beat;
  logic [TAG_W+IDX_W-1:0] victim_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  function automatic logic [TAG_W-1:0] tagf(input logic [IDX_W-1:0] i);
    tagf = TAG_W'((int'(i) * 37 + 5) % 64);
  endfunction

  assign tag_addr_i = tagf(tag_idx);

  l2_evict_seq #(.IDX_W(IDX_W), .TAG_W(TAG_W), .TAG_RD_LAT(LAT), .BEATS(BEATS)) u0 (
    .clk(clk), .rst(rst), .cfg_fast(cfg_fast), .cfg_l2_present(cfg_l2_present),
    .cfg_multi_proc(cfg_multi_proc), .req_valid(req_valid),
    .req_burst_rd(req_burst_rd), .req_index(req_index), .req_ready(req_ready),
    .bus_retry(bus_retry), .bus_ack(bus_ack), .col_hold(col_hold),
    .tag_idx(tag_idx), .tag_oe(tag_oe), .tag_we(tag_we), .tag_addr_i(tag_addr_i),
    .tag_addr_o(tag_addr_o), .tag_valid_o(tag_valid_o), .tag_valid_oe(tag_valid_oe),
    .tag_dirty_o(tag_dirty_o), .data_rd(data_rd), .data_beat(data_beat),
    .done(done), .victim_addr(victim_addr)
  );

  task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", tag, k, act, exp);
    end
  endtask

  task automatic run_one(input logic f, input logic b, input logic pres, input logic mp,
                         input logic [IDX_W-1:0] idx);
    int s;
    logic drv;
    s = f ? LAT + 1 : LAT + 2;
    @(negedge clk);
    cfg_fast = f; cfg_l2_present = pres; cfg_multi_proc = mp;
    req_valid = 1'b1; req_burst_rd = b; req_index = idx;
    @(posedge clk);
    for (int k = 1; k <= s + BEATS + 1; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_index = ~idx; req_burst_rd = ~b; cfg_fast = ~f;
      end
      drv = f ? (k <= LAT) : (k == LAT + 1);
      chk("R1 ready", k, 32'(req_ready), 32'(k == s + BEATS + 1));
      chk("R2 retry", k, 32'(bus_retry), 32'(k == 1 && !b));
      chk("R3 ack", k, 32'(bus_ack), 32'(k == 1 && b));
      chk("R4 col_hold", k, 32'(col_hold), 32'(b && k <= s + BEATS - 1));
      chk("R5 tag_oe", k, 32'(tag_oe), 32'(k <= LAT));
      if (k <= LAT) chk("R5 tag_idx", k, 32'(tag_idx), 32'(idx));
      if (k > LAT) chk("R6 victim", k, 32'(victim_addr), 32'({tagf(idx), idx}));
      chk("R7 R8 R12 tag_we", k, 32'(tag_we), 32'(f ? (k == LAT) : (k == LAT + 1)));
      chk("R7 tag_addr_o", k, 32'(tag_addr_o), (!f && k == LAT + 1) ? 32'(tagf(idx)) : 32'd0);
      chk("R8 valid", k, 32'({tag_valid_o, tag_dirty_o}), drv ? 32'd2 : 32'd0);
      chk("R9 valid_oe", k, 32'(tag_valid_oe), 32'(drv && pres && !mp));
      chk("R10 data_rd", k, 32'(data_rd), 32'(k >= s && k < s + BEATS));
      chk("R10 beat", k, 32'(data_beat), (k >= s && k < s + BEATS) ? 32'(k - s) : 32'd0);
      chk("R11 done", k, 32'(done), 32'(k == s + BEATS));
      if (k == s + BEATS) req_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset ready", 0, 32'(req_ready), 32'd1);
    chk("R11 reset outputs", 0,
        32'({bus_retry, bus_ack, col_hold, tag_oe, tag_we, data_rd, done, tag_valid_oe}), 32'd0);
    chk("R6 reset victim", 0, 32'(victim_addr), 32'd0);
    for (int f = 0; f < 2; f++)
      for (int b = 0; b < 2; b++)
        for (int c = 0; c < 3; c++)
          for (int i = 0; i < (1 << IDX_W); i++)
            run_one(f[0], b[0], c != 1, c == 2, IDX_W'(i));
    @(negedge clk);
    chk("R1 idle hold", 0, 32'({req_ready, tag_oe}), 32'd2);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R11: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule